// File: doc/BRIEF.md
# Secure Pin-Peripheral Connection Gate

This block sits between the peripherals of a chip and the pins of one I/O port and decides, pin by pin, which signal paths may stay connected. Each pin has two paths. The first is a digital path: the selected peripheral's output and output-enable go toward the pad, and the pad's input value goes back toward the peripheral. The second is an analog switch that an analog peripheral asks to close. The alternate-function multiplexer and the security configuration bank sit outside the block and supply its inputs.

The two paths use different rules. The digital path is cut when a secure peripheral is mapped to a pin that is not secure. This stops secret data from leaving through an open pin and stops pad data from reaching a secure transfer. The analog switch is held open when a non-secure analog peripheral asks for a secure pin. This stops that peripheral from sampling or disturbing the pad level of that pin. All gating depends on a global security-enable input. Every gated output is registered once, so a change of security attributes cannot glitch the pad. Each pin also has a sticky flag that records a blocked attempt, and a write-one-to-clear pulse resets it.

Top module: `pin_sec_gate`

## Requirements
- R1: While `rstN` is low, every output of the block (`padOut`, `padOe`, `perIn`, `anaSwEn`, `violFlag`) is 0.
- R2: With `tzEnable`=1, a pin whose peripheral is secure (`perSec`=1) and whose own secure bit is set (`pinSec`=1) passes `perOut`, `perOe` and `padIn` unchanged. All outputs show the inputs sampled at the previous rising clock edge (one cycle of latency).
- R3: With `tzEnable`=1, a pin with `perSec`=1 and `pinSec`=0 is blocked. One cycle later, `padOut`, `padOe` and `perIn` are 0 for that pin.
- R4: With `tzEnable`=1, a pin whose peripheral is not secure (`perSec`=0) passes all three digital signals, one cycle later, whatever `pinSec` is.
- R5: With `tzEnable`=1, a pin with `pinSec`=1 whose analog requester is not secure (`anaSec`=0) has `anaSwEn`=0 one cycle later, whatever `anaReq` is.
- R6: In every other analog case, `anaSwEn` equals `anaReq` one cycle later. A secure analog requester closes switches on secure and non-secure pins. The switch never closes without a request.
- R7: With `tzEnable`=0, every pin passes the digital and analog paths ungated, one cycle later, whatever the security bits are.
- R8: When a pin is blocked while in use, its `violFlag` bit sets one cycle later. In use means digitally blocked with `perSel`=1, or analog-blocked with `anaReq`=1. The flag then stays set until it is cleared.
- R9: A 1 on a bit of `violClr` clears that pin's `violFlag` one cycle later. A new violation in the same cycle wins and the flag stays set. Other pins' flags are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tzEnable | input | 1 | Global security enable; 0 disables all gating |
| perOut | input | NUM_PINS | Selected digital peripheral output, per pin |
| perOe | input | NUM_PINS | Selected digital peripheral output-enable, per pin |
| padIn | input | NUM_PINS | Pad input value, per pin |
| perSec | input | NUM_PINS | 1 = digital peripheral mapped to the pin is secure |
| pinSec | input | NUM_PINS | 1 = pin is secure |
| perSel | input | NUM_PINS | 1 = the mapped peripheral is actively selected |
| anaReq | input | NUM_PINS | Analog switch close request, per pin |
| anaSec | input | NUM_PINS | 1 = analog peripheral making the request is secure |
| violClr | input | NUM_PINS | Write-one-to-clear pulse for the violation flags |
| padOut | output | NUM_PINS | Gated output value toward the pad |
| padOe | output | NUM_PINS | Gated output-enable toward the pad |
| perIn | output | NUM_PINS | Gated input value toward the peripheral |
| anaSwEn | output | NUM_PINS | Final analog switch enable |
| violFlag | output | NUM_PINS | Sticky per-pin violation flags |

## Verification
Random patterns use a fixed seed and mix all four combinations of peripheral and pin security, with the global enable mostly on. This separates the pass case (R2) from the blocked case (R3) and from the pin-independent case (R4) on every pin in the same cycle. Analog requests are drawn independently of the digital bits, so a wrong choice of which security bit decides the switch shows up as a mismatch. Directed steps cover a violation held with no new cause, a clear that arrives together with a new violation, a plain clear, and blocking attributes applied while the global enable is 0.

// File: rtl/pin_sec_gate_pkg.sv
package pin_sec_gate_pkg;
  // Per-pin strobes from the decision logic to the registered datapath
  typedef struct packed {
    logic digPass;   // digital path may connect
    logic anaPass;   // analog switch may follow its request
    logic violSet;   // blocked while in use
    logic violClr;   // clear request for the sticky flag
  } gateStrobe_t;
endpackage

// File: rtl/pin_sec_gate_ctrl.sv
module pin_sec_gate_ctrl
  import pin_sec_gate_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                         tzEnable,
  input  logic [NUM_PINS-1:0]          perSec,
  input  logic [NUM_PINS-1:0]          pinSec,
  input  logic [NUM_PINS-1:0]          perSel,
  input  logic [NUM_PINS-1:0]          anaReq,
  input  logic [NUM_PINS-1:0]          anaSec,
  input  logic [NUM_PINS-1:0]          violClr,
  output gateStrobe_t [NUM_PINS-1:0]   strobes
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic digBlock;
    logic anaBlock;
    // Secure peripheral on an open pin: cut the digital path
    assign digBlock = tzEnable & perSec[p] & ~pinSec[p];
    // Open analog requester on a secure pin: keep the switch open
    assign anaBlock = tzEnable & pinSec[p] & ~anaSec[p];
    always_comb begin
      strobes[p].digPass = ~digBlock;
      strobes[p].anaPass = ~anaBlock;
      strobes[p].violSet = (digBlock & perSel[p]) | (anaBlock & anaReq[p]);
      strobes[p].violClr = violClr[p];
    end
  end
endmodule

// File: rtl/pin_sec_gate_dp.sv
module pin_sec_gate_dp
  import pin_sec_gate_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  gateStrobe_t [NUM_PINS-1:0]   strobes,
  input  logic [NUM_PINS-1:0]          perOut,
  input  logic [NUM_PINS-1:0]          perOe,
  input  logic [NUM_PINS-1:0]          padIn,
  input  logic [NUM_PINS-1:0]          anaReq,
  output logic [NUM_PINS-1:0]          padOut,
  output logic [NUM_PINS-1:0]          padOe,
  output logic [NUM_PINS-1:0]          perIn,
  output logic [NUM_PINS-1:0]          anaSwEn,
  output logic [NUM_PINS-1:0]          violFlag
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        padOut[p]   <= 1'b0;
        padOe[p]    <= 1'b0;
        perIn[p]    <= 1'b0;
        anaSwEn[p]  <= 1'b0;
        violFlag[p] <= 1'b0;
      end else begin
        padOut[p]   <= perOut[p] & strobes[p].digPass;
        padOe[p]    <= perOe[p]  & strobes[p].digPass;
        perIn[p]    <= padIn[p]  & strobes[p].digPass;
        anaSwEn[p]  <= anaReq[p] & strobes[p].anaPass;
        // new violation has priority over the clear pulse
        violFlag[p] <= (violFlag[p] & ~strobes[p].violClr) | strobes[p].violSet;
      end
    end
  end
endmodule

// File: rtl/pin_sec_gate.sv
module pin_sec_gate
  import pin_sec_gate_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tzEnable,
  input  logic [NUM_PINS-1:0] perOut,
  input  logic [NUM_PINS-1:0] perOe,
  input  logic [NUM_PINS-1:0] padIn,
  input  logic [NUM_PINS-1:0] perSec,
  input  logic [NUM_PINS-1:0] pinSec,
  input  logic [NUM_PINS-1:0] perSel,
  input  logic [NUM_PINS-1:0] anaReq,
  input  logic [NUM_PINS-1:0] anaSec,
  input  logic [NUM_PINS-1:0] violClr,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] perIn,
  output logic [NUM_PINS-1:0] anaSwEn,
  output logic [NUM_PINS-1:0] violFlag
);
  gateStrobe_t [NUM_PINS-1:0] strobes;

  pin_sec_gate_ctrl #(.NUM_PINS(NUM_PINS)) i_ctrl (
    .tzEnable(tzEnable), .perSec(perSec), .pinSec(pinSec), .perSel(perSel),
    .anaReq(anaReq), .anaSec(anaSec), .violClr(violClr), .strobes(strobes)
  );

  pin_sec_gate_dp #(.NUM_PINS(NUM_PINS)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .perOut(perOut), .perOe(perOe),
    .padIn(padIn), .anaReq(anaReq), .padOut(padOut), .padOe(padOe),
    .perIn(perIn), .anaSwEn(anaSwEn), .violFlag(violFlag)
  );
endmodule

// File: rtl/pin_sec_gate_chk.sv
module pin_sec_gate_chk #(
  parameter int NUM_PINS = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                tzEnable,
  input logic [NUM_PINS-1:0] perOut,
  input logic [NUM_PINS-1:0] perOe,
  input logic [NUM_PINS-1:0] padIn,
  input logic [NUM_PINS-1:0] perSec,
  input logic [NUM_PINS-1:0] pinSec,
  input logic [NUM_PINS-1:0] perSel,
  input logic [NUM_PINS-1:0] anaReq,
  input logic [NUM_PINS-1:0] anaSec,
  input logic [NUM_PINS-1:0] violClr,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic [NUM_PINS-1:0] perIn,
  input logic [NUM_PINS-1:0] anaSwEn,
  input logic [NUM_PINS-1:0] violFlag
);
  logic [NUM_PINS-1:0] blkMask, anaBlk, violNow;
  assign blkMask = {NUM_PINS{tzEnable}} & perSec & ~pinSec;
  assign anaBlk  = {NUM_PINS{tzEnable}} & pinSec & ~anaSec;
  assign violNow = (blkMask & perSel) | (anaBlk & anaReq);

  assert_dig_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (((padOut ^ $past(perOut)) | (padOe ^ $past(perOe))) & $past(~blkMask)) == '0);
  assert_blk_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((padOut | padOe | perIn) & $past(blkMask)) == '0);
  assert_open_per_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((perIn ^ $past(padIn)) & $past(~perSec)) == '0);
  assert_ana_open_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (anaSwEn & $past(anaBlk)) == '0);
  assert_ana_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (anaSwEn & ~$past(anaReq)) == '0);
  assert_no_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN && !tzEnable) |-> (padOe == $past(perOe)) && (anaSwEn == $past(anaReq))
                                 && (perIn == $past(padIn)));
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (~violFlag & $past(violNow)) == '0);
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((violFlag ^ $past(violFlag)) & $past(~violNow & ~violClr)) == '0);
  assert_flag_clr_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (violFlag & $past(violClr & ~violNow)) == '0);
endmodule

bind pin_sec_gate pin_sec_gate_chk #(.NUM_PINS(NUM_PINS)) i_chk (
  .clk(clk), .rstN(rstN), .tzEnable(tzEnable), .perOut(perOut), .perOe(perOe),
  .padIn(padIn), .perSec(perSec), .pinSec(pinSec), .perSel(perSel),
  .anaReq(anaReq), .anaSec(anaSec), .violClr(violClr), .padOut(padOut),
  .padOe(padOe), .perIn(perIn), .anaSwEn(anaSwEn), .violFlag(violFlag)
);

// File: tb/test_pin_sec_gate.sv
`timescale 1ns/1ps
module test_pin_sec_gate;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tzEnable;
  logic [N-1:0] perOut, perOe, padIn, perSec, pinSec, perSel, anaReq, anaSec, violClr;
  logic [N-1:0] padOut, padOe, perIn, anaSwEn, violFlag;

  // next-step stimulus
  logic nTz;
  logic [N-1:0] nPerOut, nPerOe, nPadIn, nPerSec, nPinSec, nPerSel, nAnaReq, nAnaSec, nViolClr;

  // expected outputs and tags
  logic [N-1:0] ePadOut, ePadOe, ePerIn, eAna, eFlag;
  string tagDig [N];
  string tagAna [N];
  string tagFlg [N];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pin_sec_gate #(.NUM_PINS(N)) i_pin_sec_gate (
    .clk(clk), .rstN(rstN), .tzEnable(tzEnable), .perOut(perOut), .perOe(perOe),
    .padIn(padIn), .perSec(perSec), .pinSec(pinSec), .perSel(perSel),
    .anaReq(anaReq), .anaSec(anaSec), .violClr(violClr), .padOut(padOut),
    .padOe(padOe), .perIn(perIn), .anaSwEn(anaSwEn), .violFlag(violFlag)
  );

  task automatic chk(input string tag, input int pin, input string what,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pin %0d %s actual %b expected %b", tag, pin, what, act, exp);
    end
  endtask

  function automatic logic digBlocked(input logic tz, input logic ps, input logic ns);
    return tz & ps & ~ns;
  endfunction

  function automatic logic anaBlocked(input logic tz, input logic ns, input logic as);
    return tz & ns & ~as;
  endfunction

  // Apply the next stimulus and compute the expected outputs one cycle on
  task automatic applyNext();
    tzEnable = nTz; perOut = nPerOut; perOe = nPerOe; padIn = nPadIn;
    perSec = nPerSec; pinSec = nPinSec; perSel = nPerSel;
    anaReq = nAnaReq; anaSec = nAnaSec; violClr = nViolClr;
    for (int p = 0; p < N; p++) begin
      logic db, ab, v;
      db = digBlocked(nTz, nPerSec[p], nPinSec[p]);
      ab = anaBlocked(nTz, nPinSec[p], nAnaSec[p]);
      ePadOut[p] = db ? 1'b0 : nPerOut[p];
      ePadOe[p]  = db ? 1'b0 : nPerOe[p];
      ePerIn[p]  = db ? 1'b0 : nPadIn[p];
      eAna[p]    = ab ? 1'b0 : nAnaReq[p];
      tagDig[p]  = !nTz ? "R7" : (db ? "R3" : (nPerSec[p] ? "R2" : "R4"));
      tagAna[p]  = !nTz ? "R7" : (ab ? "R5" : "R6");
      v = (db & nPerSel[p]) | (ab & nAnaReq[p]);
      tagFlg[p]  = nViolClr[p] ? "R9" : "R8";
      eFlag[p]   = (eFlag[p] & ~nViolClr[p]) | v;
    end
  endtask

  task automatic checkOut();
    for (int p = 0; p < N; p++) begin
      chk(tagDig[p], p, "padOut", padOut[p], ePadOut[p]);
      chk(tagDig[p], p, "padOe", padOe[p], ePadOe[p]);
      chk(tagDig[p], p, "perIn", perIn[p], ePerIn[p]);
      chk(tagAna[p], p, "anaSwEn", anaSwEn[p], eAna[p]);
      chk(tagFlg[p], p, "violFlag", violFlag[p], eFlag[p]);
    end
  endtask

  task automatic step();
    @(negedge clk);
    checkOut();
    applyNext();
  endtask

  task automatic randNext();
    nTz = ($urandom % 4) != 0;
    nPerOut = N'($urandom); nPerOe = N'($urandom); nPadIn = N'($urandom);
    nPerSec = N'($urandom); nPinSec = N'($urandom); nPerSel = N'($urandom);
    nAnaReq = N'($urandom); nAnaSec = N'($urandom);
    nViolClr = N'($urandom) & N'($urandom) & N'($urandom);
  endtask

  task automatic quietNext();
    nTz = 1'b1; nPerOut = '1; nPerOe = '1; nPadIn = '1;
    nPerSec = '0; nPinSec = '1; nPerSel = '1; nAnaReq = '1; nAnaSec = '1; nViolClr = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // inputs busy during reset: outputs must still read zero (R1)
    randNext();
    nTz = 1'b1; nPerSec = '1; nPinSec = '0; nPerSel = '1;
    tzEnable = nTz; perOut = '1; perOe = '1; padIn = '1; perSec = nPerSec;
    pinSec = nPinSec; perSel = nPerSel; anaReq = '1; anaSec = '0; violClr = '0;
    repeat (3) @(negedge clk);
    for (int p = 0; p < N; p++) begin
      chk("R1", p, "padOut", padOut[p], 1'b0);
      chk("R1", p, "padOe", padOe[p], 1'b0);
      chk("R1", p, "perIn", perIn[p], 1'b0);
      chk("R1", p, "anaSwEn", anaSwEn[p], 1'b0);
      chk("R1", p, "violFlag", violFlag[p], 1'b0);
    end
    rstN = 1'b1;
    eFlag = '0;
    randNext();
    applyNext();

    for (int i = 0; i < 400; i++) begin
      randNext();
      step();
    end

    // directed: clear everything, then a digital violation on pin 0 (R8)
    quietNext(); nViolClr = '1; step();
    quietNext(); step();
    quietNext(); nPerSec[0] = 1'b1; nPinSec[0] = 1'b0; step();
    // held with no cause and no clear (R8)
    quietNext(); step();
    quietNext(); step();
    // clear coinciding with a new violation: flag stays (R9)
    quietNext(); nPerSec[0] = 1'b1; nPinSec[0] = 1'b0; nViolClr[0] = 1'b1; step();
    // clear of another pin leaves pin 0 alone (R9)
    quietNext(); nViolClr[1] = 1'b1; step();
    // plain clear (R9)
    quietNext(); nViolClr[0] = 1'b1; step();
    // analog violation on pin 2 (R5, R8)
    quietNext(); nAnaSec[2] = 1'b0; step();
    // global enable off with blocking attributes everywhere (R7)
    quietNext(); nTz = 1'b0; nPerSec = '1; nPinSec = '0; nAnaSec = '0; step();
    quietNext(); nTz = 1'b0; nPerSec = '1; nPinSec = '1; nAnaSec = '0; nViolClr = '1; step();
    // secure analog requester closes on open and secure pins (R6)
    quietNext(); nAnaSec = '1; nPinSec = 16'h00FF; step();
    quietNext(); step();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule